// File: doc/BRIEF.md
# Intra-Group Store-Load Overlap Detector

This block watches one instruction candidate per cycle while an issue stage fills a dispatch group. It keeps a small table of the stores accepted so far in the current group. Each stored entry holds two address operands and an access size. When the candidate is a load, the block compares the load's address against every recorded store. If any store could touch the same bytes, it raises a no-op hazard. The scheduler then pads the group instead of issuing the load.

The block also remembers whether a move into the count register has been accepted in the current group. If a branch through the count register is then presented, the block raises the same no-op hazard. A group-end pulse from the group-formation logic empties the table and drops the counter flag.

Each address operand is a 16-bit value with a flag that marks it as a constant offset or as a register tag. Two operands are equal only when both the flag and the value agree. The first operand of an access is the offset or index, and the second is the base. The hazard output is combinational on the candidate inputs. Recording happens on a clock edge when the commit input is high.

Top module: `grp_alias_guard`

## Requirements
- R1: The size code gives the access length in bytes: code 0 is 1, code 1 is 2, code 2 is 4, code 3 is 8, code 4 is 16, and codes 5 to 7 are also treated as 16.
- R2: A load candidate raises `noop_hazard_o` in the same cycle it is presented when both its operands equal the two operands of a recorded store, in the same order.
- R3: A load candidate also raises the hazard when its operands equal a recorded store's operands in swapped order: load first equals store second, and load second equals store first.
- R4: When the load and a store have equal second operands and both first operands are constants, the hazard is raised exactly when the byte ranges overlap. That is, the lower offset plus its own access length is greater than the higher offset; for equal offsets the load's length is used. Ranges that only touch do not raise it.
- R5: When the second operands match but a first operand is not a constant, only the equality rules of R2 and R3 apply.
- R6: Store-table hits are reported only for a load candidate. Kind codes are 0 other, 1 load, 2 store, 3 count-register move, 4 branch through count register, and 5 to 7 other. No kind other than 1 and 4 ever raises the hazard.
- R7: A committed kind 3 sets the counter flag. A kind 4 candidate raises the hazard while the flag is set, and does not raise it otherwise.
- R8: `grp_end_i` empties the table and clears the counter flag at the next edge. A commit in that same cycle is recorded as the first event of the new group.
- R9: A committed store is appended at the current store count, and the count then increments. Once DEPTH (5) stores are held, further store commits are ignored until the group ends.
- R10: After reset the table is empty and the counter flag is clear, so no candidate raises the hazard.
- R11: The offset-plus-length sum in R4 is formed one bit wider than the offset, so an access near offset 0xFFFF does not wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_end_i | input | 1 | Current group ends at this edge |
| commit_i | input | 1 | Candidate is accepted at this edge |
| kind_i | input | 3 | Candidate kind code (R6) |
| opa_val_i | input | 16 | First operand value (offset or index) |
| opa_const_i | input | 1 | First operand is a constant |
| opb_val_i | input | 16 | Second operand value (base) |
| opb_const_i | input | 1 | Second operand is a constant |
| size_i | input | 3 | Access size code (R1) |
| noop_hazard_o | output | 1 | Candidate needs a no-op inserted before it |

## Verification
Directed loads are placed just below, just inside, exactly on, and just past a stored byte range. These tell a correct overlap rule apart from an off-by-one or a comparison that uses the wrong access length. Swapped and non-constant operand pairs separate the equality rules from the range rule. A store near offset 0xFFFF exposes a sum that wraps. Random streams draw from a small pool of tags and offsets, mixed with group ends, commits that coincide with group ends, and more than five stores per group, so that table clearing, the ignored sixth store and the counter flag are all hit often.

// File: rtl/alias_pkg.sv
package alias_pkg;

  localparam int OFFSET_W  = 16;
  localparam int SZCODE_W  = 3;
  localparam int BYTES_W   = 5;
  localparam int KIND_W    = 3;

  typedef enum logic [KIND_W-1:0] {
    K_OTHER    = 3'd0,
    K_LOAD     = 3'd1,
    K_STORE    = 3'd2,
    K_CTR_MOVE = 3'd3,
    K_CTR_BR   = 3'd4
  } kind_e;

  typedef struct packed {
    logic                is_const;
    logic [OFFSET_W-1:0] val;
  } operand_t;

  typedef struct packed {
    logic                valid;
    operand_t            opa;
    operand_t            opb;
    logic [SZCODE_W-1:0] size_code;
  } st_entry_t;

  // R1: size code to byte length, codes above 4 saturate at 16 bytes
  function automatic logic [BYTES_W-1:0] size_bytes(input logic [SZCODE_W-1:0] code);
    logic [BYTES_W-1:0] len;
    if (code >= SZCODE_W'(4)) len = BYTES_W'(16);
    else                      len = BYTES_W'(1) << code;
    return len;
  endfunction

  function automatic logic operand_eq(input operand_t x, input operand_t y);
    return (x.is_const == y.is_const) && (x.val == y.val);
  endfunction

  // R4/R11: lower start plus its own length must pass the higher start; widened sum
  function automatic logic ranges_overlap(input logic [OFFSET_W-1:0] st_off,
                                          input logic [BYTES_W-1:0]  st_len,
                                          input logic [OFFSET_W-1:0] ld_off,
                                          input logic [BYTES_W-1:0]  ld_len);
    logic [OFFSET_W:0] st_end;
    logic [OFFSET_W:0] ld_end;
    logic              ov;
    st_end = {1'b0, st_off} + {{(OFFSET_W+1-BYTES_W){1'b0}}, st_len};
    ld_end = {1'b0, ld_off} + {{(OFFSET_W+1-BYTES_W){1'b0}}, ld_len};
    if (st_off < ld_off) ov = st_end > {1'b0, ld_off};
    else                 ov = ld_end > {1'b0, st_off};
    return ov;
  endfunction

endpackage

// File: rtl/alias_entry_cmp.sv
module alias_entry_cmp
  import alias_pkg::*;
(
  input  st_entry_t           entry_i,
  input  operand_t            q_a_i,
  input  operand_t            q_b_i,
  input  logic [SZCODE_W-1:0] q_size_i,
  output logic                hit_o
);

  logic exact_hit;
  logic swap_hit;
  logic base_eq;
  logic both_const;
  logic range_hit;

  always_comb begin
    exact_hit  = operand_eq(entry_i.opa, q_a_i) && operand_eq(entry_i.opb, q_b_i);
    swap_hit   = operand_eq(entry_i.opa, q_b_i) && operand_eq(entry_i.opb, q_a_i);
    base_eq    = operand_eq(entry_i.opb, q_b_i);
    both_const = entry_i.opa.is_const && q_a_i.is_const;
    range_hit  = base_eq && both_const &&
                 ranges_overlap(entry_i.opa.val, size_bytes(entry_i.size_code),
                                q_a_i.val, size_bytes(q_size_i));
    hit_o      = entry_i.valid && (exact_hit || swap_hit || range_hit);
  end

endmodule

// File: rtl/alias_store_table.sv
module alias_store_table
  import alias_pkg::*;
#(
  parameter int DEPTH = 5,
  localparam int CNT_W = $clog2(DEPTH + 1)
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear_i,
  input  logic                  push_i,
  input  operand_t              push_a_i,
  input  operand_t              push_b_i,
  input  logic [SZCODE_W-1:0]   push_size_i,
  output st_entry_t [DEPTH-1:0] entries_o,
  output logic [CNT_W-1:0]      count_o
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  st_entry_t [DEPTH-1:0] tbl_q;
  logic [CNT_W-1:0]      cnt_q;
  logic [CNT_W-1:0]      base_cnt;
  logic                  room;
  logic                  do_write;

  always_comb begin
    base_cnt = clear_i ? '0 : cnt_q;
    room     = base_cnt < FULL;
    do_write = push_i && room;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (do_write) begin
      cnt_q <= base_cnt + CNT_W'(1);
    end else begin
      cnt_q <= base_cnt;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_sel;
    assign slot_sel = do_write && (base_cnt == CNT_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tbl_q[g] <= '0;
      end else if (slot_sel) begin
        tbl_q[g].valid     <= 1'b1;
        tbl_q[g].opa       <= push_a_i;
        tbl_q[g].opb       <= push_b_i;
        tbl_q[g].size_code <= push_size_i;
      end else if (clear_i) begin
        tbl_q[g].valid <= 1'b0;
      end
    end
  end

  assign entries_o = tbl_q;
  assign count_o   = cnt_q;

  // R9: append advances the count by one
  assert_push_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    push_i && !clear_i && (cnt_q < FULL) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  // R9: a push into a full table is dropped
  assert_full_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    push_i && !clear_i && (cnt_q == FULL) |=> cnt_q == FULL);

  // R8: clear with a simultaneous push leaves exactly one entry
  assert_clear_push_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i && push_i |=> cnt_q == CNT_W'(1) && tbl_q[0].valid);

  // R8: clear alone empties the table
  assert_clear_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i && !push_i |=> cnt_q == '0 && !tbl_q[0].valid);

endmodule

// File: rtl/alias_ctr_flag.sv
module alias_ctr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic set_i,
  output logic flag_o
);

  logic flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (set_i)   flag_q <= 1'b1;
    else if (clear_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  // R7: an accepted counter move is remembered
  assert_ctr_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);

  // R8: group end without a move drops the flag
  assert_ctr_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i && !set_i |=> !flag_o);

  // R7: the flag never rises on its own
  assert_ctr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !set_i && !clear_i |=> flag_o == $past(flag_o));

endmodule

// File: rtl/grp_alias_guard.sv
module grp_alias_guard
  import alias_pkg::*;
#(
  parameter int DEPTH = 5
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                grp_end_i,
  input  logic                commit_i,
  input  logic [KIND_W-1:0]   kind_i,
  input  logic [OFFSET_W-1:0] opa_val_i,
  input  logic                opa_const_i,
  input  logic [OFFSET_W-1:0] opb_val_i,
  input  logic                opb_const_i,
  input  logic [SZCODE_W-1:0] size_i,
  output logic                noop_hazard_o
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  operand_t              q_a;
  operand_t              q_b;
  logic                  is_load;
  logic                  is_ctr_br;
  logic                  store_push;
  logic                  ctr_set;
  st_entry_t [DEPTH-1:0] entries;
  logic [CNT_W-1:0]      st_count;
  logic [DEPTH-1:0]      hit_vec;
  logic                  ctr_flag;
  logic                  load_hit;
  logic                  ctr_hit;

  always_comb begin
    q_a.is_const = opa_const_i;
    q_a.val      = opa_val_i;
    q_b.is_const = opb_const_i;
    q_b.val      = opb_val_i;
    is_load      = kind_i == K_LOAD;
    is_ctr_br    = kind_i == K_CTR_BR;
    store_push   = commit_i && (kind_i == K_STORE);
    ctr_set      = commit_i && (kind_i == K_CTR_MOVE);
  end

  alias_store_table #(.DEPTH(DEPTH)) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (grp_end_i),
    .push_i     (store_push),
    .push_a_i   (q_a),
    .push_b_i   (q_b),
    .push_size_i(size_i),
    .entries_o  (entries),
    .count_o    (st_count)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    alias_entry_cmp u_cmp (
      .entry_i (entries[g]),
      .q_a_i   (q_a),
      .q_b_i   (q_b),
      .q_size_i(size_i),
      .hit_o   (hit_vec[g])
    );
  end

  alias_ctr_flag u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear_i(grp_end_i),
    .set_i  (ctr_set),
    .flag_o (ctr_flag)
  );

  always_comb begin
    load_hit      = is_load && (st_count != '0) && (|hit_vec);
    ctr_hit       = is_ctr_br && ctr_flag;
    noop_hazard_o = load_hit || ctr_hit;
  end

  // R6: kinds other than load and counter branch stay quiet
  assert_kind_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !is_load && !is_ctr_br |-> !noop_hazard_o);

  // R10: an empty table gives no load hazard
  assert_empty_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    is_load && (st_count == '0) |-> !noop_hazard_o);

  // R8: after a bare group end nothing is flagged
  assert_grp_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    grp_end_i && !commit_i |=> !noop_hazard_o);

  // R7: counter branch without a prior move is clean
  assert_ctr_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    is_ctr_br && !ctr_flag |-> !noop_hazard_o);

endmodule

// File: tb/grp_alias_guard_tb.sv
module grp_alias_guard_tb_top;

  localparam int DEPTH = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        grp_end_i = 1'b0;
  logic        commit_i = 1'b0;
  logic [2:0]  kind_i = 3'd0;
  logic [15:0] opa_val_i = '0;
  logic        opa_const_i = 1'b0;
  logic [15:0] opb_val_i = '0;
  logic        opb_const_i = 1'b0;
  logic [2:0]  size_i = 3'd0;
  logic        noop_hazard_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  // model state: operands held as {const, value}
  bit [16:0] m_a [DEPTH];
  bit [16:0] m_b [DEPTH];
  int        m_sz [DEPTH];
  int        m_cnt = 0;
  bit        m_flag = 1'b0;

  always #10 clk = ~clk;

  grp_alias_guard #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .grp_end_i(grp_end_i), .commit_i(commit_i),
    .kind_i(kind_i), .opa_val_i(opa_val_i), .opa_const_i(opa_const_i),
    .opb_val_i(opb_val_i), .opb_const_i(opb_const_i), .size_i(size_i),
    .noop_hazard_o(noop_hazard_o)
  );

  function automatic bit [16:0] K(input int v);
    return {1'b1, 16'(v)};
  endfunction

  function automatic bit [16:0] T(input int v);
    return {1'b0, 16'(v)};
  endfunction

  function automatic int len_of(input int code);
    case (code)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 8;
      default: return 16;
    endcase
  endfunction

  // interval form: overlap when the later start lies before the earlier end
  function automatic bit span_clash(input int s0, input int l0, input int s1, input int l1);
    int lo_end;
    int hi_start;
    hi_start = (s0 > s1) ? s0 : s1;
    lo_end   = ((s0 + l0) < (s1 + l1)) ? (s0 + l0) : (s1 + l1);
    return hi_start < lo_end;
  endfunction

  function automatic bit model_hazard(input int kind, input bit [16:0] a, input bit [16:0] b,
                                      input int sz);
    bit h;
    h = 1'b0;
    if (kind == 4) h = m_flag;
    if (kind == 1) begin
      for (int i = 0; i < m_cnt; i++) begin
        if (a == m_a[i] && b == m_b[i]) h = 1'b1;
        if (a == m_b[i] && b == m_a[i]) h = 1'b1;
        if (b == m_b[i] && a[16] && m_a[i][16] &&
            span_clash(int'(m_a[i][15:0]), len_of(m_sz[i]), int'(a[15:0]), len_of(sz)))
          h = 1'b1;
      end
    end
    return h;
  endfunction

  task automatic check(input bit act, input bit exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: noop_hazard_o=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int kind, input bit [16:0] a, input bit [16:0] b, input int sz,
                      input bit com, input bit gend, input string req);
    bit exp;
    @(negedge clk);
    kind_i      = 3'(kind);
    opa_const_i = a[16];
    opa_val_i   = a[15:0];
    opb_const_i = b[16];
    opb_val_i   = b[15:0];
    size_i      = 3'(sz);
    commit_i    = com;
    grp_end_i   = gend;
    #2;
    exp = model_hazard(kind, a, b, sz);
    check(noop_hazard_o, exp, req);
    @(posedge clk);
    #1;
    if (gend) begin
      m_cnt  = 0;
      m_flag = 1'b0;
    end
    if (com && kind == 2 && m_cnt < DEPTH) begin
      m_a[m_cnt]  = a;
      m_b[m_cnt]  = b;
      m_sz[m_cnt] = sz;
      m_cnt++;
    end
    if (com && kind == 3) m_flag = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    // R10: hazard low during and after reset
    kind_i = 3'd1;
    repeat (3) @(posedge clk);
    #2;
    check(noop_hazard_o, 1'b0, "R10 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    step(1, K(0), T(1), 0, 0, 0, "R10 after reset load");
    step(4, T(0), T(0), 0, 0, 0, "R10 after reset ctr branch");

    // R2/R3/R4/R5/R6 around one word store at offset 8 of base 1
    step(0, T(0), T(0), 0, 0, 1, "R8 group end");
    step(2, K(8), T(1), 2, 1, 0, "R6 store commit");
    step(1, K(8), T(1), 2, 0, 0, "R2 exact match");
    step(1, T(1), K(8), 2, 0, 0, "R3 swapped match");
    step(1, K(12), T(1), 2, 0, 0, "R4 touching above");
    step(1, K(4), T(1), 2, 0, 0, "R4 touching below");
    step(1, K(4), T(1), 3, 0, 0, "R4 longer load reaches store");
    step(1, K(11), T(1), 0, 0, 0, "R4 last byte");
    step(1, K(8), T(2), 2, 0, 0, "R4 other base");
    step(2, T(5), T(1), 0, 1, 0, "R5 indexed store commit");
    step(1, T(6), T(1), 0, 0, 0, "R5 other index");
    step(1, T(5), T(1), 0, 0, 0, "R5 same index");
    step(0, K(8), T(1), 2, 0, 0, "R6 kind other");
    step(2, K(8), T(1), 2, 0, 0, "R6 kind store");
    step(6, K(8), T(1), 2, 0, 0, "R6 kind 6");

    // R11: store at 0xFFF8 of 16 bytes covers 0xFFFF
    step(0, T(0), T(0), 0, 0, 1, "R8 group end");
    step(2, K(16'hFFF8), T(2), 4, 1, 0, "R11 high store");
    step(1, K(16'hFFFF), T(2), 0, 0, 0, "R11 no wrap");
    step(1, K(0), T(2), 0, 0, 0, "R11 low offset clear");

    // R1: codes 5..7 act as 16 bytes
    step(2, K(32), T(4), 5, 1, 0, "R1 code5 store");
    step(1, K(47), T(4), 0, 0, 0, "R1 code5 last byte");
    step(1, K(48), T(4), 0, 0, 0, "R1 code5 past end");
    step(1, K(20), T(4), 7, 0, 0, "R1 code7 load reaches");
    step(1, K(16), T(4), 7, 0, 0, "R1 code7 load touching");

    // R9: sixth store dropped
    step(0, T(0), T(0), 0, 0, 1, "R8 group end");
    for (int i = 0; i < DEPTH; i++) step(2, K(16 * i), T(7), 0, 1, 0, "R9 fill");
    step(2, K(100), T(7), 0, 1, 0, "R9 extra store");
    step(1, K(100), T(7), 0, 0, 0, "R9 extra ignored");
    step(1, K(64), T(7), 0, 0, 0, "R9 fifth held");

    // R8: group end plus commit in the same cycle
    step(2, K(200), T(8), 0, 1, 1, "R8 end with store");
    step(1, K(0), T(7), 0, 0, 0, "R8 old entry gone");
    step(1, K(200), T(8), 0, 0, 0, "R8 new entry kept");

    // R7: counter move then branch
    step(0, T(0), T(0), 0, 0, 1, "R8 group end");
    step(4, T(0), T(0), 0, 0, 0, "R7 branch without move");
    step(3, T(0), T(0), 0, 0, 0, "R7 move not committed");
    step(4, T(0), T(0), 0, 0, 0, "R7 still clean");
    step(3, T(0), T(0), 0, 1, 0, "R7 move commit");
    step(4, T(0), T(0), 0, 0, 0, "R7 branch after move");
    step(1, T(0), T(0), 0, 0, 0, "R7 load unaffected");
    step(0, T(0), T(0), 0, 0, 1, "R8 group end");
    step(4, T(0), T(0), 0, 0, 0, "R8 flag cleared");
    step(3, T(0), T(0), 0, 1, 1, "R8 end with move");
    step(4, T(0), T(0), 0, 0, 0, "R8 move kept");

    // random mix over a small operand pool
    for (int n = 0; n < 4000; n++) begin
      int        kd;
      bit [16:0] ra;
      bit [16:0] rb;
      kd = $urandom_range(0, 9);
      if (kd > 7) kd = 2;
      ra = ($urandom_range(0, 1) == 1) ? K($urandom_range(0, 40)) : T($urandom_range(1, 3));
      rb = ($urandom_range(0, 5) == 0) ? K($urandom_range(0, 40)) : T($urandom_range(1, 2));
      step(kd, ra, rb, $urandom_range(0, 7), $urandom_range(0, 1) == 1,
           $urandom_range(0, 6) == 0, "R2 R3 R4 R7 R9 random");
    end

    finish_run();
  end

endmodule